// File: doc/BRIEF.md
# Condition Register and Branch Evaluator

This block keeps a 32-bit condition register, organised as eight 4-bit fields, together with a loop count register, and decides whether a conditional branch is taken. A compare request names a target field and two operands. The second operand can be a register value or a 16-bit immediate, and the compare can be signed or unsigned. The block writes the compare outcome into the target field. An arithmetic or logical operation that records its result instead sends that result, and field 0 is updated as if the result had been compared with zero.

A branch request selects one condition bit and the value that bit must have. It also chooses a count mode, which either leaves the count register alone or decrements it and tests the new value for nonzero or for zero. A move-to-count operation loads the count register. The current count is always visible on `ctr_out` for move-from operations. A branch decision comes out one cycle after the request. At the same clock edge the count register takes its decremented value. The count update never changes the condition register.

A two-state reporting machine sequences the output. The state `ST_IDLE` moves to `ST_REPORT` when a branch request is present (transition *accept*). `ST_REPORT` moves back to `ST_IDLE` when no new request arrives (transition *retire*). `ST_REPORT` stays in `ST_REPORT` when another request arrives (transition *chain*). `ST_IDLE` stays in `ST_IDLE` when there is no request (transition *wait*). `br_done` is high exactly while the machine is in `ST_REPORT`.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset, `cr_out` and `ctr_out` are zero, and `br_done` and `br_taken` are low.
- R2: Field f occupies `cr_out[31-4f -: 4]`, ordered {LT, GT, EQ, SO} from its most significant bit. A compare sets exactly one of LT, GT and EQ in that field. LT means operand A is below operand B. The comparison is two's complement when `cmp_unsigned` is 0 and unsigned when it is 1.
- R3: With `cmp_use_imm` set, operand B is `cmp_imm`. The immediate is sign-extended for a signed compare and zero-extended for an unsigned compare.
- R4: A compare copies `so_in` into the SO bit of the field it writes. It leaves the other seven fields unchanged.
- R5: When `rec_valid` is set, field 0 takes the result of a signed compare of `rec_result` against zero, with SO taken from `so_in`. If a compare to field 0 arrives in the same cycle, the compare wins.
- R6: The condition bit n (0..31) selected by `br_bit` is `cr_out[31-n]`. With `br_test_cond` set, the branch requires that bit to equal `br_sense`. With `br_test_cond` clear, the bit is not tested.
- R7: `br_mode` 0 leaves the count unchanged and places no count condition. Mode 1 decrements the count and requires the new count to be nonzero. Mode 2 decrements the count and requires the new count to be zero. Mode 3 leaves the count unchanged and is never taken.
- R8: A combined branch is taken only when both the count condition and the bit condition hold. The count still decrements when the bit condition fails.
- R9: A count decrement leaves `cr_out` unchanged. A move-to-count in the same cycle as a decrement wins.
- R10: A branch issued in the same cycle as a compare or record update is judged on the condition register value from before that update.
- R11: `br_done` rises in the cycle after each branch request. It stays high for one cycle for a lone request. `br_taken` is high only while `br_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| so_in | input | 1 | Summary overflow value copied into written fields |
| cmp_valid | input | 1 | Compare request |
| cmp_field | input | 3 | Target field of the compare |
| cmp_unsigned | input | 1 | 1 = unsigned compare, 0 = signed |
| cmp_use_imm | input | 1 | 1 = operand B is the immediate |
| cmp_a | input | 32 | Operand A |
| cmp_b | input | 32 | Register operand B |
| cmp_imm | input | 16 | Immediate operand B |
| rec_valid | input | 1 | Result-recording update of field 0 |
| rec_result | input | 32 | Result compared with zero |
| ctr_wr | input | 1 | Move-to-count request |
| ctr_wr_data | input | 32 | Value loaded into the count register |
| br_valid | input | 1 | Branch request |
| br_bit | input | 5 | Condition bit number to test |
| br_sense | input | 1 | Required value of that bit |
| br_test_cond | input | 1 | 1 = bit condition applies |
| br_mode | input | 2 | Count mode (see R7) |
| br_done | output | 1 | Branch decision valid |
| br_taken | output | 1 | Branch taken |
| ctr_out | output | 32 | Count register value |
| cr_out | output | 32 | Condition register value |

## Verification
Two pairs of functions can meet in one cycle. The first is a compare and a branch that tests the very bit the compare sets. The second is a move-to-count and a decrementing branch. The bench drives each pair on the same clock edge. In the first case it expects a decision based on the old condition bit, and a following branch must then see the new bit. In the second case it expects the loaded value to survive, while the decision still uses the old count. The record-versus-compare collision on field 0 is provoked in the same way and judged on `cr_out`.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [1:0] {
        CTR_IGNORE  = 2'd0,
        CTR_NONZERO = 2'd1,
        CTR_ZERO    = 2'd2,
        CTR_NEVER   = 2'd3
    } ctr_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rpt_state_e;

endpackage

// File: rtl/cbu_compare.sv
module cbu_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              is_unsigned,
    input  logic              so,
    output logic [3:0]        flags
);
    logic lt, eq;

    always_comb begin
        eq = (op_a == op_b);
        if (is_unsigned) lt = (op_a < op_b);
        else             lt = ($signed(op_a) < $signed(op_b));
        flags = {lt, !lt && !eq, eq, so};
    end
endmodule

// File: rtl/cbu_cr_file.sv
module cbu_cr_file #(
    parameter int NFIELD = 8,
    localparam int FIELD_W = 4,
    localparam int CR_W = NFIELD * FIELD_W,
    localparam int FSEL_W = $clog2(NFIELD)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_we,
    input  logic [FSEL_W-1:0]  cmp_field,
    input  logic [FIELD_W-1:0] cmp_bits,
    input  logic               rec_we,
    input  logic [FIELD_W-1:0] rec_bits,
    output logic [CR_W-1:0]    cr_q
);
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        localparam bit IS_F0 = (f == 0);
        logic [FIELD_W-1:0] fq;
        logic               hit_cmp;
        logic               hit_rec;

        assign hit_cmp = cmp_we && (cmp_field == FSEL_W'(f));
        assign hit_rec = rec_we && IS_F0;

        always_ff @(posedge clk) begin
            if (!rst_n)       fq <= '0;
            else if (hit_cmp) fq <= cmp_bits;
            else if (hit_rec) fq <= rec_bits;
        end

        assign cr_q[CR_W-1-FIELD_W*f -: FIELD_W] = fq;
    end
endmodule

// File: rtl/cbu_ctr.sv
module cbu_ctr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dec,
    output logic [DATA_W-1:0] ctr_q,
    output logic [DATA_W-1:0] ctr_next_dec
);
    assign ctr_next_dec = ctr_q - DATA_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)   ctr_q <= '0;
        else if (wr)  ctr_q <= wr_data;
        else if (dec) ctr_q <= ctr_next_dec;
    end
endmodule

// File: rtl/cbu_branch_eval.sv
module cbu_branch_eval
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CR_W = 32,
    localparam int BSEL_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]   cr,
    input  logic [DATA_W-1:0] ctr_dec,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic              sense,
    input  logic              test_cond,
    input  logic [1:0]        mode,
    output logic              taken,
    output logic              do_dec
);
    logic [CR_W-1:0] cr_rev;
    logic            ctr_ok, cond_ok;
    ctr_mode_e       m;

    for (genvar i = 0; i < CR_W; i++) begin : g_rev
        assign cr_rev[i] = cr[CR_W-1-i];
    end

    always_comb begin
        m       = ctr_mode_e'(mode);
        cond_ok = !test_cond || (cr_rev[bit_sel] == sense);
        do_dec  = 1'b0;
        ctr_ok  = 1'b0;
        unique case (m)
            CTR_IGNORE:  ctr_ok = 1'b1;
            CTR_NONZERO: begin do_dec = 1'b1; ctr_ok = (ctr_dec != '0); end
            CTR_ZERO:    begin do_dec = 1'b1; ctr_ok = (ctr_dec == '0); end
            CTR_NEVER:   ctr_ok = 1'b0;
        endcase
        taken = ctr_ok && cond_ok;
    end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W = 16,
    parameter int NFIELD = 8,
    localparam int CR_W = NFIELD * 4,
    localparam int FSEL_W = $clog2(NFIELD),
    localparam int BSEL_W = $clog2(CR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              so_in,
    input  logic              cmp_valid,
    input  logic [FSEL_W-1:0] cmp_field,
    input  logic              cmp_unsigned,
    input  logic              cmp_use_imm,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [IMM_W-1:0]  cmp_imm,
    input  logic              rec_valid,
    input  logic [DATA_W-1:0] rec_result,
    input  logic              ctr_wr,
    input  logic [DATA_W-1:0] ctr_wr_data,
    input  logic              br_valid,
    input  logic [BSEL_W-1:0] br_bit,
    input  logic              br_sense,
    input  logic              br_test_cond,
    input  logic [1:0]        br_mode,
    output logic              br_done,
    output logic              br_taken,
    output logic [DATA_W-1:0] ctr_out,
    output logic [CR_W-1:0]   cr_out
);
    logic [DATA_W-1:0] op_b_eff;
    logic [3:0]        cmp_flags, rec_flags;
    logic [DATA_W-1:0] ctr_dec;
    logic              eval_taken, eval_dec;
    logic              taken_q;
    rpt_state_e        state_q, state_d;

    always_comb begin
        if (!cmp_use_imm)      op_b_eff = cmp_b;
        else if (cmp_unsigned) op_b_eff = {{(DATA_W-IMM_W){1'b0}}, cmp_imm};
        else                   op_b_eff = {{(DATA_W-IMM_W){cmp_imm[IMM_W-1]}}, cmp_imm};
    end

    cbu_compare #(.DATA_W(DATA_W)) u_cmp (
        .op_a(cmp_a), .op_b(op_b_eff), .is_unsigned(cmp_unsigned),
        .so(so_in), .flags(cmp_flags)
    );

    cbu_compare #(.DATA_W(DATA_W)) u_rec (
        .op_a(rec_result), .op_b('0), .is_unsigned(1'b0),
        .so(so_in), .flags(rec_flags)
    );

    cbu_cr_file #(.NFIELD(NFIELD)) u_cr (
        .clk(clk), .rst_n(rst_n),
        .cmp_we(cmp_valid), .cmp_field(cmp_field), .cmp_bits(cmp_flags),
        .rec_we(rec_valid), .rec_bits(rec_flags),
        .cr_q(cr_out)
    );

    cbu_branch_eval #(.DATA_W(DATA_W), .CR_W(CR_W)) u_eval (
        .cr(cr_out), .ctr_dec(ctr_dec), .bit_sel(br_bit), .sense(br_sense),
        .test_cond(br_test_cond), .mode(br_mode),
        .taken(eval_taken), .do_dec(eval_dec)
    );

    cbu_ctr #(.DATA_W(DATA_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .wr(ctr_wr), .wr_data(ctr_wr_data),
        .dec(br_valid && eval_dec), .ctr_q(ctr_out), .ctr_next_dec(ctr_dec)
    );

    // reporting machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            taken_q <= 1'b0;
        end else begin
            state_q <= state_d;
            taken_q <= br_valid && eval_taken;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = br_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = br_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    // reporting machine: outputs
    always_comb begin
        br_done  = 1'b0;
        br_taken = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_REPORT: begin br_done = 1'b1; br_taken = taken_q; end
        endcase
    end

    logic [CR_W-1:0] cr_rev;
    for (genvar i = 0; i < CR_W; i++) begin : g_crrev
        assign cr_rev[i] = cr_out[CR_W-1-i];
    end

    AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> $onehot({cr_rev[{$past(cmp_field), 2'd0}],
                               cr_rev[{$past(cmp_field), 2'd1}],
                               cr_rev[{$past(cmp_field), 2'd2}]})); // R2
    AST_SO_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> cr_rev[{$past(cmp_field), 2'd3}] == $past(so_in)); // R4
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && (br_mode == 2'd1 || br_mode == 2'd2) && !ctr_wr
        |=> ctr_out == $past(ctr_out) - DATA_W'(1)); // R7
    AST_DEC_KEEPS_CR: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && !cmp_valid && !rec_valid |=> $stable(cr_out)); // R9
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> br_done); // R11
    AST_TAKEN_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> br_done); // R11
endmodule

// File: tb/cond_branch_unit_tb.sv
`timescale 1ns/1ps
module cond_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        so_in = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_field = '0;
    logic        cmp_unsigned = 1'b0;
    logic        cmp_use_imm = 1'b0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic [15:0] cmp_imm = '0;
    logic        rec_valid = 1'b0;
    logic [31:0] rec_result = '0;
    logic        ctr_wr = 1'b0;
    logic [31:0] ctr_wr_data = '0;
    logic        br_valid = 1'b0;
    logic [4:0]  br_bit = '0;
    logic        br_sense = 1'b0;
    logic        br_test_cond = 1'b0;
    logic [1:0]  br_mode = '0;
    logic        br_done, br_taken;
    logic [31:0] ctr_out, cr_out;

    always #2 clk = ~clk;

    cond_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .so_in(so_in),
        .cmp_valid(cmp_valid), .cmp_field(cmp_field), .cmp_unsigned(cmp_unsigned),
        .cmp_use_imm(cmp_use_imm), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_imm(cmp_imm),
        .rec_valid(rec_valid), .rec_result(rec_result),
        .ctr_wr(ctr_wr), .ctr_wr_data(ctr_wr_data),
        .br_valid(br_valid), .br_bit(br_bit), .br_sense(br_sense),
        .br_test_cond(br_test_cond), .br_mode(br_mode),
        .br_done(br_done), .br_taken(br_taken), .ctr_out(ctr_out), .cr_out(cr_out)
    );

    typedef struct {
        logic        taken;
        logic [31:0] ctr;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_tests = 0;
    int          n_fail = 0;
    logic [31:0] m_cr = '0;
    logic [31:0] m_ctr = '0;
    bit          finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model of a compare per R2/R3
    function automatic logic [3:0] flags_of(input logic [31:0] a, input logic [31:0] b,
                                            input logic uns, input logic so);
        logic lt, eq;
        eq = (a == b);
        lt = uns ? (a < b) : ($signed(a) < $signed(b));
        return {lt, !lt && !eq, eq, so};
    endfunction

    function automatic logic [31:0] imm_ext(input logic [15:0] imm, input logic uns);
        return uns ? {16'h0, imm} : {{16{imm[15]}}, imm};
    endfunction

    // monitor: pop and compare as decisions appear
    always @(negedge clk) begin
        if (rst_n && br_done) begin
            if (sb_q.size() == 0) begin
                check("R11 unexpected done", 32'(br_done), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " taken"}, 32'(br_taken), 32'(e.taken));
                check({e.tag, " count"}, ctr_out, e.ctr);
            end
        end
    end

    task automatic clear_inputs();
        cmp_valid = 1'b0; rec_valid = 1'b0; ctr_wr = 1'b0; br_valid = 1'b0;
    endtask

    // drives stimulus of one cycle; optional compare, record, move-to and branch together
    task automatic step(input bit do_cmp, input int f, input logic [31:0] a, input logic [31:0] b,
                        input logic uns, input logic use_imm, input logic [15:0] imm,
                        input bit do_rec, input logic [31:0] res,
                        input bit do_mt, input logic [31:0] mt_val,
                        input bit do_br, input int bsel, input logic sense,
                        input logic tcond, input logic [1:0] mode, input string tag);
        logic [31:0] dec;
        logic        ctr_ok, cond_ok;
        exp_t        e;
        @(negedge clk);
        cmp_valid = do_cmp; cmp_field = 3'(f); cmp_a = a; cmp_b = b;
        cmp_unsigned = uns; cmp_use_imm = use_imm; cmp_imm = imm;
        rec_valid = do_rec; rec_result = res;
        ctr_wr = do_mt; ctr_wr_data = mt_val;
        br_valid = do_br; br_bit = 5'(bsel); br_sense = sense;
        br_test_cond = tcond; br_mode = mode;
        if (do_br) begin
            dec = m_ctr - 1;
            cond_ok = !tcond || (m_cr[31-bsel] == sense);
            case (mode)
                2'd0: ctr_ok = 1'b1;
                2'd1: ctr_ok = (dec != 0);
                2'd2: ctr_ok = (dec == 0);
                default: ctr_ok = 1'b0;
            endcase
            e.taken = ctr_ok && cond_ok;
            if (do_mt) e.ctr = mt_val;
            else if (mode == 2'd1 || mode == 2'd2) e.ctr = dec;
            else e.ctr = m_ctr;
            e.tag = tag;
            sb_q.push_back(e);
            m_ctr = e.ctr;
        end else if (do_mt) begin
            m_ctr = mt_val;
        end
        if (do_rec) m_cr[31 -: 4] = flags_of(res, 32'd0, 1'b0, so_in);
        if (do_cmp) m_cr[31-4*f -: 4] = flags_of(a, use_imm ? imm_ext(imm, uns) : b, uns, so_in);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic cmp(input int f, input logic [31:0] a, input logic [31:0] b, input logic uns,
                       input logic use_imm, input logic [15:0] imm);
        step(1, f, a, b, uns, use_imm, imm, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, "");
    endtask

    task automatic br(input int bsel, input logic sense, input logic tcond,
                      input logic [1:0] mode, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, bsel, sense, tcond, mode, tag);
        // lone request: done must drop again (R11)
        @(negedge clk);
        check({tag, " R11 done pulse"}, 32'(br_done), 32'd0);
    endtask

    task automatic mtctr(input logic [31:0] v);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, 0, 0, 2'd0, "");
    endtask

    task automatic check_state(input string tag);
        check({tag, " cr"}, cr_out, m_cr);
        check({tag, " ctr"}, ctr_out, m_ctr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cr", cr_out, 32'd0);
        check("R1 ctr", ctr_out, 32'd0);
        check("R1 done", 32'(br_done), 32'd0);
        check("R1 taken", 32'(br_taken), 32'd0);
        rst_n = 1'b1;

        // R2 + R4: signed compare into field 3 with SO set
        so_in = 1'b1;
        cmp(3, 32'hFFFF_FFFB, 32'd3, 1'b0, 1'b0, 16'h0);
        check("R2 signed LT field3", 32'(cr_out[19:16]), 32'b1001);
        check_state("R4 other fields");
        // R2: same operands unsigned into field 5, SO clear
        so_in = 1'b0;
        cmp(5, 32'hFFFF_FFFB, 32'd3, 1'b1, 1'b0, 16'h0);
        check("R2 unsigned GT field5", 32'(cr_out[11:8]), 32'b0100);
        cmp(6, 32'd77, 32'd77, 1'b0, 1'b0, 16'h0);
        check_state("R2 EQ field6");

        // R3: immediate extension
        cmp(1, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b1, 16'hFFFF);
        check("R3 signed imm EQ", 32'(cr_out[27:24]), 32'b0010);
        cmp(1, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1, 16'hFFFF);
        check("R3 unsigned imm GT", 32'(cr_out[27:24]), 32'b0100);
        cmp(2, 32'h0000_8000, 32'd0, 1'b0, 1'b1, 16'h8000);
        check_state("R3 signed imm large");

        // R5: record update to field 0
        so_in = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 2'd0, "");
        check("R5 rec negative", 32'(cr_out[31:28]), 32'b1001);
        so_in = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'd0, 0, 0, 0, 0, 0, 0, 2'd0, "");
        check("R5 rec zero", 32'(cr_out[31:28]), 32'b0010);
        step(1, 0, 32'd9, 32'd1, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 2'd0, "");
        check("R5 compare wins over record", 32'(cr_out[31:28]), 32'b0100);

        // R6: bit tests (field3 LT = bit 12 set, field5 LT = bit 20 clear)
        br(12, 1'b1, 1'b1, 2'd0, "R6 bit12 set");
        br(12, 1'b0, 1'b1, 2'd0, "R6 bit12 want clear");
        br(20, 1'b0, 1'b1, 2'd0, "R6 bit20 clear");
        br(15, 1'b0, 1'b1, 2'd0, "R6 bit15 SO");
        br(20, 1'b1, 1'b0, 2'd0, "R6 untested bit");

        // R7: count modes
        mtctr(32'd3);
        br(0, 0, 0, 2'd1, "R7 nz 3->2");
        br(0, 0, 0, 2'd1, "R7 nz 2->1");
        br(0, 0, 0, 2'd1, "R7 nz 1->0");
        br(0, 0, 0, 2'd1, "R7 nz wrap");
        mtctr(32'd1);
        br(0, 0, 0, 2'd2, "R7 z 1->0");
        br(0, 0, 0, 2'd3, "R7 never");
        br(0, 0, 0, 2'd2, "R7 z wrap");

        // R8: combined
        mtctr(32'd5);
        br(12, 1'b1, 1'b1, 2'd1, "R8 nz and bit set");
        br(12, 1'b0, 1'b1, 2'd1, "R8 nz bit mismatch");
        mtctr(32'd1);
        br(20, 1'b0, 1'b1, 2'd2, "R8 z and bit clear");

        // R9: cr untouched by decrements, move-to wins
        check_state("R9 after decrements");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'd40, 1, 0, 0, 0, 2'd1, "R9 mt with dec");
        check_state("R9 move-to wins");

        // R10: compare and branch together on field2 EQ (bit 10), old value 0
        step(1, 2, 32'd4, 32'd4, 0, 0, 0, 0, 0, 0, 0, 1, 10, 1'b1, 1'b1, 2'd0, "R10 old cr");
        br(10, 1'b1, 1'b1, 2'd0, "R10 new cr");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'd5, 0, 0, 1, 2, 1'b1, 1'b1, 2'd0, "R10 record vs branch");
        check_state("R10 final");

        // R11: back-to-back requests keep done high
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1'b0, 1'b1, 2'd0, "R11 first");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1'b1, 1'b1, 2'd0, "R11 second");
        repeat (2) @(negedge clk);
        check("R11 queue drained", 32'(sb_q.size()), 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule